// File: doc/BRIEF.md
# Register-Programmed SPI Host Controller

This block is a serial peripheral interface host that a processor drives through a small 32-bit register window. Software first places the block in its configuration mode. There it picks the clock polarity, the clock phase, which end of a word leaves first, the word width (8 or 16 bits) and the SCK divider. It then switches the block to active mode. Every word written to the data register goes into a 4-entry transmit queue and is shifted out on MOSI. The bits clocked in on MISO during that same word form a receive word, which lands in a 4-entry receive queue. Software reads the received words back through the same data register.

A status register reports the occupancy of both queues, two threshold flags and an idle indication. A single level interrupt tells software that the receive queue holds at least the number of words it asked for. Chip selects are not part of this block. The system drives them from general-purpose outputs around each transfer.

Registers by byte offset: mode control 0x00, control A 0x04, control B 0x08, status 0x14, data 0x18. Undefined offsets read as zero and ignore writes.

Top module: `spi_host_ctrl`

## Requirements
- R1: After reset the mode-control register reads 0x40 (config mode), status reads 0x8004, `irq` is 0 and `sck` is 0.
- R2: Writes to control B (divider in bits 15:8, word-length field in bits 4:0) and to control A bits 2:0 take effect only while mode bits 7:6 equal 01. Control A bits 15:8 are writable in any mode.
- R3: A word starts shifting only while mode bits 7:6 equal 10 and the transmit queue is non-empty. Words written in config mode stay queued.
- R4: The divider value d (0 is treated as 1) gives d+1 clock cycles from one leading SCK edge to the next.
- R5: Control A bit 0 sets the SCK idle level. With bit 1 clear, MISO is captured on the leading edge and MOSI changes on the trailing edge. With bit 1 set, MOSI changes on the leading edge and MISO is captured on the trailing edge.
- R6: With control A bit 2 clear the word leaves MSB first. With bit 2 set it leaves LSB first. Received bits are placed in the same order.
- R7: A word-length field of 16 shifts 16 bits per word. Any other value shifts 8 bits.
- R8: The bits captured from MISO during a word are pushed into the receive queue as one word, zero-extended to 32 bits when read.
- R9: Both queues hold 4 words. A data write to a full transmit queue is dropped. A data read pops the receive queue and returns 0 when it is empty. Status bits 13:11 and 10:8 give the transmit and receive occupancy.
- R10: Status bit 14 is set while receive occupancy is at least control A bits 13:12 plus one. `irq` is high only while (bit 14 and control A bit 9) or (bit 15 and control A bit 8).
- R11: Status bit 15 is set while transmit occupancy is at most control A bits 15:14.
- R12: Writing the mode-control register with bit 0 set empties both queues.
- R13: Status bit 2 is set exactly when the transmit queue is empty and no word is in flight, including the cycle that stores the received word.
- R14: While mode-control bit 1 is set, no new word starts. A word already in flight finishes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, also the SCK base clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe (pops the receive queue at the data offset) |
| reg_addr | input | 5 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| irq | output | 1 | Level interrupt |

## Verification
Register writes and the queue clear take effect at the clock edge that samples the strobe. The bench changes inputs on falling edges and reads status on the following falling edge. Read data is combinational, so the bench samples it just after setting the address, and the pop happens at the next rising edge.

A word begins one edge after the active-mode write. It then takes bits × (d+1) cycles, plus one more cycle to store the received word. The bench therefore polls the idle bit before it reads any result, and never relies on a fixed wait. Serial timing is measured at falling edges of `clk` by counting cycles between rising SCK transitions. A bench-side slave samples MOSI and advances MISO on the SCK edges that the selected mode defines.

// File: rtl/spi_host_pkg.sv
// Package: shared offsets, mode codes and the shifter configuration record
// used by the SPI host controller. Assumes a 5-bit byte offset space.
package spi_host_pkg;

    localparam logic [1:0] OPM_CFG = 2'b01;
    localparam logic [1:0] OPM_ACT = 2'b10;

    localparam logic [4:0] ADR_MODE = 5'h00;
    localparam logic [4:0] ADR_CTLA = 5'h04;
    localparam logic [4:0] ADR_CTLB = 5'h08;
    localparam logic [4:0] ADR_STAT = 5'h14;
    localparam logic [4:0] ADR_DATA = 5'h18;

    localparam int WIDE_BITS = 16;

    typedef struct packed {
        logic       cpol;
        logic       cpha;
        logic       lsb_first;
        logic       wide;
        logic [7:0] div;
    } shift_cfg_t;

endpackage

// File: rtl/spi_word_fifo.sv
// Synchronous word queue. A push while full and a pop while empty are
// ignored; clr empties it. The head word is visible combinationally.
// Assumes one clock domain and DEPTH >= 2.
module spi_word_fifo #(
    parameter  int DEPTH = 4,
    parameter  int WIDTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    // Pointer wrap helper for non-power-of-two depths.
    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    // Storage write on accepted push.
    always_ff @(posedge clk) begin
        if (do_push && !clr) mem[wr_ptr] <= wdata;
    end

    // Pointer and occupancy tracking.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= nxt(wr_ptr);
            if (do_pop)  rd_ptr <= nxt(rd_ptr);
            count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end
endmodule

// File: rtl/spi_shift_engine.sv
// Serial engine: takes one word when allowed, produces SCK with a period of
// div+1 core cycles (idle half rounded up), drives MOSI and captures MISO
// per the phase setting, then emits the captured word for one cycle.
// Assumes the configuration stays stable while a word is in flight.
module spi_shift_engine
    import spi_host_pkg::*;
#(
    parameter  int WORD_W = WIDE_BITS,
    parameter  int DIV_W  = 8,
    localparam int CNT_W  = DIV_W + 1,
    localparam int BIT_W  = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_ok,
    input  logic              tx_avail,
    input  logic [WORD_W-1:0] tx_word,
    output logic              tx_take,
    input  shift_cfg_t        cfg,
    input  logic              miso,
    output logic              sck,
    output logic              mosi,
    output logic              rx_valid,
    output logic [WORD_W-1:0] rx_data,
    output logic              busy
);
    logic              run_q, lead_q, push_q, mosi_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [BIT_W-1:0]  idx_q;
    logic [WORD_W-1:0] word_q, cap_q;

    logic [CNT_W-1:0]  period, hi_len, lo_len;
    logic [BIT_W-1:0]  last_idx;
    logic              edge_lead, edge_trail, last_bit;

    // Half-period lengths derived from the divider.
    always_comb begin
        period   = (cfg.div == '0) ? CNT_W'(2) : CNT_W'(cfg.div) + CNT_W'(1);
        hi_len   = period >> 1;
        lo_len   = period - hi_len;
        last_idx = cfg.wide ? BIT_W'(WORD_W - 1) : BIT_W'(WORD_W / 2 - 1);
    end

    // Map bit sequence number to word bit position.
    function automatic logic [BIT_W-1:0] pos(input logic [BIT_W-1:0] i,
                                             input logic lsb,
                                             input logic [BIT_W-1:0] last);
        return lsb ? i : last - i;
    endfunction

    assign tx_take    = !run_q && go_ok && tx_avail;
    assign edge_lead  = run_q && !lead_q && (cnt_q == lo_len - CNT_W'(1));
    assign edge_trail = run_q && lead_q && (cnt_q == hi_len - CNT_W'(1));
    assign last_bit   = (idx_q == last_idx);

    // Word sequencing, SCK phase tracking, MOSI drive and MISO capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            lead_q <= 1'b0;
            push_q <= 1'b0;
            mosi_q <= 1'b0;
            cnt_q  <= '0;
            idx_q  <= '0;
            word_q <= '0;
            cap_q  <= '0;
        end else begin
            push_q <= 1'b0;
            if (tx_take) begin
                run_q  <= 1'b1;
                lead_q <= 1'b0;
                cnt_q  <= '0;
                idx_q  <= '0;
                word_q <= tx_word;
                if (!cfg.cpha) mosi_q <= tx_word[pos('0, cfg.lsb_first, last_idx)];
            end else if (edge_lead) begin
                lead_q <= 1'b1;
                cnt_q  <= '0;
                if (!cfg.cpha) cap_q[pos(idx_q, cfg.lsb_first, last_idx)] <= miso;
                else           mosi_q <= word_q[pos(idx_q, cfg.lsb_first, last_idx)];
            end else if (edge_trail) begin
                lead_q <= 1'b0;
                cnt_q  <= '0;
                if (cfg.cpha) cap_q[pos(idx_q, cfg.lsb_first, last_idx)] <= miso;
                if (last_bit) begin
                    run_q  <= 1'b0;
                    push_q <= 1'b1;
                end else begin
                    idx_q <= idx_q + BIT_W'(1);
                    if (!cfg.cpha)
                        mosi_q <= word_q[pos(idx_q + BIT_W'(1), cfg.lsb_first, last_idx)];
                end
            end else if (run_q) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    assign sck      = cfg.cpol ^ lead_q;
    assign mosi     = mosi_q;
    assign rx_valid = push_q;
    assign rx_data  = cfg.wide ? cap_q : {{(WORD_W/2){1'b0}}, cap_q[WORD_W/2-1:0]};
    assign busy     = run_q | push_q;
endmodule

// File: rtl/spi_host_ctrl.sv
// Top: register window, two word queues and the serial engine.
// Configuration fields that shape the serial format change only in config
// mode; interrupt enables and fill levels change in any mode.
// Assumes a single-cycle register bus with combinational read data.
module spi_host_ctrl
    import spi_host_pkg::*;
#(
    parameter  int FIFO_DEPTH = 4,
    parameter  int WORD_W     = WIDE_BITS,
    parameter  int DIV_W      = 8,
    parameter  int ADDR_W     = 5,
    parameter  int DATA_W     = 32,
    localparam int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic              reg_rd_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic              irq
);
    logic [1:0]       opmode_q;
    logic             stop_q;
    logic [1:0]       txfl_q, rxfl_q;
    logic             rxie_q, txie_q;
    logic             lsb_q, cpha_q, cpol_q;
    logic [DIV_W-1:0] div_q;
    logic [4:0]       wlen_q;

    logic             wr_mode, wr_ctla, wr_ctlb, wr_data, rd_pop, cfg_mode;
    logic             fifo_clr, tx_take, rx_push, eng_busy;
    logic [WORD_W-1:0] tx_head, rx_head, rx_word;
    logic [CNT_W-1:0] tx_cnt, rx_cnt;
    logic             tx_full, tx_empty, rx_full, rx_empty;
    logic             tx_flag, rx_flag, idle;
    shift_cfg_t       cfg;

    assign cfg_mode = (opmode_q == OPM_CFG);
    assign wr_mode  = reg_wr_en && (reg_addr == ADR_MODE);
    assign wr_ctla  = reg_wr_en && (reg_addr == ADR_CTLA);
    assign wr_ctlb  = reg_wr_en && (reg_addr == ADR_CTLB);
    assign wr_data  = reg_wr_en && (reg_addr == ADR_DATA);
    assign rd_pop   = reg_rd_en && (reg_addr == ADR_DATA);
    assign fifo_clr = wr_mode && reg_wdata[0];

    // Control register storage with config-mode gating of format fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opmode_q <= OPM_CFG;
            stop_q   <= 1'b0;
            txfl_q   <= '0;
            rxfl_q   <= '0;
            rxie_q   <= 1'b0;
            txie_q   <= 1'b0;
            lsb_q    <= 1'b0;
            cpha_q   <= 1'b0;
            cpol_q   <= 1'b0;
            div_q    <= DIV_W'(1);
            wlen_q   <= 5'd8;
        end else begin
            if (wr_mode) begin
                opmode_q <= reg_wdata[7:6];
                stop_q   <= reg_wdata[1];
            end
            if (wr_ctla) begin
                txfl_q <= reg_wdata[15:14];
                rxfl_q <= reg_wdata[13:12];
                rxie_q <= reg_wdata[9];
                txie_q <= reg_wdata[8];
                if (cfg_mode) begin
                    lsb_q  <= reg_wdata[2];
                    cpha_q <= reg_wdata[1];
                    cpol_q <= reg_wdata[0];
                end
            end
            if (wr_ctlb && cfg_mode) begin
                div_q  <= reg_wdata[8 +: DIV_W];
                wlen_q <= reg_wdata[4:0];
            end
        end
    end

    // Shifter configuration record.
    always_comb begin
        cfg.cpol      = cpol_q;
        cfg.cpha      = cpha_q;
        cfg.lsb_first = lsb_q;
        cfg.wide      = (wlen_q == 5'd16);
        cfg.div       = 8'(div_q);
    end

    spi_word_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(WORD_W)) u_txq (
        .clk(clk), .rst_n(rst_n), .clr(fifo_clr),
        .push(wr_data), .wdata(reg_wdata[WORD_W-1:0]),
        .pop(tx_take), .head(tx_head), .count(tx_cnt),
        .full(tx_full), .empty(tx_empty)
    );

    spi_word_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(WORD_W)) u_rxq (
        .clk(clk), .rst_n(rst_n), .clr(fifo_clr),
        .push(rx_push), .wdata(rx_word),
        .pop(rd_pop), .head(rx_head), .count(rx_cnt),
        .full(rx_full), .empty(rx_empty)
    );

    spi_shift_engine #(.WORD_W(WORD_W), .DIV_W(DIV_W)) u_eng (
        .clk(clk), .rst_n(rst_n),
        .go_ok((opmode_q == OPM_ACT) && !stop_q),
        .tx_avail(!tx_empty), .tx_word(tx_head), .tx_take(tx_take),
        .cfg(cfg), .miso(miso), .sck(sck), .mosi(mosi),
        .rx_valid(rx_push), .rx_data(rx_word), .busy(eng_busy)
    );

    // Threshold flags, idle and interrupt.
    always_comb begin
        tx_flag = (tx_cnt <= CNT_W'(txfl_q));
        rx_flag = (rx_cnt >= CNT_W'(rxfl_q) + CNT_W'(1));
        idle    = tx_empty && !eng_busy;
        irq     = (rx_flag && rxie_q) || (tx_flag && txie_q);
    end

    // Read data multiplexer.
    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADR_MODE: reg_rdata[7:0] = {opmode_q, 4'b0, stop_q, 1'b0};
            ADR_CTLA: reg_rdata[15:0] = {txfl_q, rxfl_q, 2'b0, rxie_q, txie_q,
                                         5'b0, lsb_q, cpha_q, cpol_q};
            ADR_CTLB: reg_rdata[15:0] = {8'(div_q), 3'b0, wlen_q};
            ADR_STAT: reg_rdata[15:0] = {tx_flag, rx_flag, 3'(tx_cnt), 3'(rx_cnt),
                                         5'b0, idle, 2'b0};
            ADR_DATA: reg_rdata = rx_empty ? '0 : DATA_W'(rx_head);
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/spi_host_ctrl_chk.sv
// Checker bound to the SPI host top: protocol and state properties.
module spi_host_ctrl_chk #(
    parameter int DEPTH = 4,
    parameter int CNT_W = 3,
    parameter int DIV_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq,
    input logic             sck,
    input logic             cpol,
    input logic             eng_busy,
    input logic [1:0]       opmode,
    input logic             stop,
    input logic [CNT_W-1:0] tx_cnt,
    input logic [CNT_W-1:0] rx_cnt,
    input logic [DIV_W-1:0] div,
    input logic             rd_pop,
    input logic             rx_push,
    input logic             fifo_clr,
    input logic             rxie,
    input logic             txie
);
    // R5: SCK rests at the polarity level between words.
    p_sck_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_busy |-> sck == cpol);

    // R3 / R14: a word only starts from active mode with stop clear.
    p_start_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eng_busy) |-> $past(opmode == 2'b10 && !stop));

    // R2: divider holds outside config mode.
    p_div_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (opmode != 2'b01) |=> $stable(div));

    // R9: occupancy never exceeds depth.
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_cnt <= CNT_W'(DEPTH)) && (rx_cnt <= CNT_W'(DEPTH)));

    // R9: a data read pops exactly one receive word.
    p_pop_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_pop && rx_cnt != '0 && !rx_push && !fifo_clr) |=>
        rx_cnt == $past(rx_cnt) - CNT_W'(1));

    // R10: the interrupt needs at least one enable.
    p_irq_enabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (rxie || txie));
endmodule

bind spi_host_ctrl spi_host_ctrl_chk #(.DEPTH(FIFO_DEPTH), .CNT_W(CNT_W), .DIV_W(DIV_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .irq(irq), .sck(sck), .cpol(cpol_q),
    .eng_busy(eng_busy), .opmode(opmode_q), .stop(stop_q),
    .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .div(div_q), .rd_pop(rd_pop),
    .rx_push(rx_push), .fifo_clr(fifo_clr), .rxie(rxie_q), .txie(txie_q)
);

// File: tb/spi_host_ctrl_tb.sv
module spi_host_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        sck, mosi, miso, irq;

    int checks = 0, fails = 0;
    bit done = 0;

    // bench-side slave
    logic        tb_cpol = 0, tb_cpha = 0;
    int          tb_wl = 8;
    int          s_idx = 0;
    logic [15:0] slv_line = '0, mosi_line = '0;

    always #4 clk = ~clk;

    spi_host_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sck(sck), .mosi(mosi), .miso(miso), .irq(irq)
    );

    assign miso = slv_line[s_idx % tb_wl];

    always @(posedge sck) if (tb_cpol == tb_cpha) begin
        mosi_line[s_idx % tb_wl] = mosi; s_idx = s_idx + 1;
    end
    always @(negedge sck) if (tb_cpol != tb_cpha) begin
        mosi_line[s_idx % tb_wl] = mosi; s_idx = s_idx + 1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr_en = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr_en = 0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk); reg_rd_en = 1; reg_addr = a; #1 d = reg_rdata;
        @(negedge clk); reg_rd_en = 0;
    endtask

    task automatic peek(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk); reg_addr = a; #1 d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] st;
        for (int i = 0; i < 3000; i++) begin
            peek(5'h14, st);
            if (st[2]) break;
        end
    endtask

    function automatic logic [15:0] line_of(input logic [15:0] w, input int wl, input bit lsb);
        logic [15:0] b = '0;
        for (int i = 0; i < wl; i++) b[i] = lsb ? w[i] : w[wl-1-i];
        return b;
    endfunction

    task automatic configure(input bit pol, input bit pha, input bit lsb, input bit wide, input int dv);
        wr(5'h00, 32'h41);
        wr(5'h04, {29'b0, lsb, pha, pol});
        wr(5'h08, (dv << 8) | (wide ? 16 : 8));
        tb_cpol = pol; tb_cpha = pha; tb_wl = wide ? 16 : 8;
        repeat (3) @(negedge clk);
        s_idx = 0; mosi_line = '0;
    endtask

    // R5 R6 R7 R8: one word in a given format
    task automatic t_word(input bit pol, input bit pha, input bit lsb, input bit wide,
                          input int dv, input logic [15:0] txw, input logic [15:0] slw);
        logic [31:0] d;
        logic [15:0] mask = wide ? 16'hFFFF : 16'h00FF;
        configure(pol, pha, lsb, wide, dv);
        chk("R5 idle sck level", {31'b0, sck}, {31'b0, pol});
        slv_line = line_of(slw & mask, tb_wl, lsb);
        wr(5'h18, {16'b0, txw});
        wr(5'h00, 32'h80);
        wait_idle();
        chk("R7 edges per word", s_idx, tb_wl);
        chk("R6 R5 mosi line order", {16'b0, mosi_line}, {16'b0, line_of(txw & mask, tb_wl, lsb)});
        rd(5'h18, d);
        chk("R8 received word", d, {16'b0, slw & mask});
    endtask

    task automatic t_reset();
        logic [31:0] d;
        peek(5'h00, d); chk("R1 mode reset", d, 32'h40);
        peek(5'h14, d); chk("R1 status reset", d, 32'h8004);
        chk("R1 irq/sck reset", {30'b0, irq, sck}, 32'h0);
    endtask

    task automatic t_gating();
        logic [31:0] d;
        configure(0, 0, 0, 0, 1);
        wr(5'h00, 32'h80);
        wr(5'h08, 32'h0510);
        peek(5'h08, d); chk("R2 ctlB locked in active", d, 32'h0108);
        wr(5'h04, 32'h0207);
        peek(5'h04, d); chk("R2 ctlA format locked, enables open", d, 32'h0200);
        wr(5'h00, 32'h41);
        wr(5'h08, 32'h0510);
        peek(5'h08, d); chk("R2 ctlB writable in config", d, 32'h0510);
        wr(5'h04, 32'h0);
    endtask

    task automatic t_hold();
        logic [31:0] d;
        configure(0, 0, 0, 0, 1);
        slv_line = 16'h0;
        wr(5'h18, 32'h3C);
        repeat (20) @(negedge clk);
        peek(5'h14, d);
        chk("R3 word held in config", {29'b0, d[13:11]}, 1);
        chk("R13 not idle with queued word", {31'b0, d[2]}, 0);
        wr(5'h00, 32'h82);
        repeat (20) @(negedge clk);
        peek(5'h14, d);
        chk("R14 stop holds queue", {29'b0, d[13:11]}, 1);
        chk("R14 no sck edges while stopped", s_idx, 0);
        wr(5'h00, 32'h80);
        wait_idle();
        peek(5'h14, d);
        chk("R13 idle after word, rx stored", {29'b0, d[10:8]}, 1);
        rd(5'h18, d);
    endtask

    task automatic t_rate();
        int first = -1, second = -1;
        logic prev;
        logic [31:0] d;
        configure(0, 0, 0, 0, 3);
        wr(5'h18, 32'h55);
        wr(5'h00, 32'h80);
        prev = sck;
        for (int c = 0; c < 200; c++) begin
            @(negedge clk);
            if (sck && !prev) begin
                if (first < 0) first = c; else if (second < 0) second = c;
            end
            prev = sck;
        end
        chk("R4 cycles per sck period, div 3", second - first, 4);
        wait_idle();
        rd(5'h18, d);
    endtask

    task automatic t_fifo();
        logic [31:0] d;
        configure(0, 0, 0, 0, 1);
        slv_line = line_of(16'h00A5, 8, 0);
        for (int i = 0; i < 5; i++) wr(5'h18, 32'h10 + i);
        peek(5'h14, d);
        chk("R9 fifth write dropped", {29'b0, d[13:11]}, 4);
        wr(5'h00, 32'h80);
        wait_idle();
        peek(5'h14, d);
        chk("R9 rx occupancy", {29'b0, d[10:8]}, 4);
        for (int i = 0; i < 4; i++) begin
            rd(5'h18, d);
            chk("R9 R8 rx word", d, 32'hA5);
        end
        rd(5'h18, d);
        chk("R9 empty read returns 0", d, 32'h0);
        chk("R7 edges for four words", s_idx, 32);
    endtask

    task automatic t_thresh();
        logic [31:0] d;
        configure(0, 0, 0, 0, 1);
        slv_line = 16'h0;
        wr(5'h04, 32'h5000);
        peek(5'h14, d); chk("R11 tx flag with empty queue", {31'b0, d[15]}, 1);
        wr(5'h18, 32'h1); wr(5'h18, 32'h2);
        peek(5'h14, d); chk("R11 tx flag clear above level", {31'b0, d[15]}, 0);
        wr(5'h00, 32'h80);
        wait_idle();
        peek(5'h14, d);
        chk("R10 rx flag at level", {31'b0, d[14]}, 1);
        chk("R10 irq masked", {31'b0, irq}, 0);
        wr(5'h04, 32'h5200);
        @(negedge clk);
        chk("R10 irq with enable", {31'b0, irq}, 1);
        rd(5'h18, d);
        peek(5'h14, d);
        chk("R10 rx flag drops below level", {31'b0, d[14]}, 0);
        chk("R10 irq drops", {31'b0, irq}, 0);
        wr(5'h00, 32'h41);
        peek(5'h14, d); chk("R12 clear empties rx", {29'b0, d[10:8]}, 0);
        wr(5'h18, 32'h7); wr(5'h18, 32'h8);
        wr(5'h00, 32'h41);
        peek(5'h14, d); chk("R12 clear empties tx", {29'b0, d[13:11]}, 0);
        wr(5'h04, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_gating();
        t_word(0, 0, 0, 0, 1, 16'h00B2, 16'h004D);
        t_word(0, 1, 0, 0, 1, 16'h0071, 16'h00C6);
        t_word(1, 0, 0, 0, 2, 16'h009E, 16'h0033);
        t_word(1, 1, 1, 0, 1, 16'h0013, 16'h00E8);
        t_word(1, 1, 1, 1, 2, 16'hA1C4, 16'h5E27);
        t_word(0, 0, 0, 1, 0, 16'h8001, 16'h7FFE);
        t_hold();
        t_rate();
        t_fifo();
        t_thresh();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL R13 watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule